// File: doc/BRIEF.md
# Antenna Array Beam Steering Sequencer

This block works out a 2-bit switch setting for every element of a phased antenna array. It holds 420 elements by default. A trigger starts a sweep, and the block then walks the elements in order, one per clock. For each element it reads the element's X, Y and Z position from on-chip tables. It forms a phase from the positions and a set of signed fixed-point steering coefficients. It then looks up a state word using that phase together with a 2-bit mode. Last, it picks one bit pair of the word, chosen by the element's health code.

Software or a loader fills the five tables through one write port before a sweep. The steering inputs are captured at the trigger, so a host may set up the next beam while the current sweep is running. Results leave through a write strobe with the element index, ready to be stored in a driver register file.

Top module: `beam_steer_seq`

## Requirements
- R1: After reset, busy_o, done_o and res_we_o are low.
- R2: A trigger seen while idle makes busy_o high from the next cycle. busy_o stays high through the cycle of the last result strobe. In the cycle that follows, done_o is high for exactly one cycle and busy_o is low. The strobe for the last element comes after the 424th rising edge following the accepting edge, and done_o after the 425th.
- R3: A trigger seen while busy_o is high has no effect: the sweep still delivers exactly 420 results, in order, with no restart.
- R4: Results come out on consecutive cycles with res_idx_o = 0, 1, ..., 419. The strobe for element 0 is high after the fifth rising edge following the edge that accepted the trigger.
- R5: Every value is a 24-bit two's-complement number with 18 fraction bits. Each product X·kx, Y·ky, Z·kz is the full signed product with the low 18 bits dropped, keeping the next 24 bits. phase = px + py + pz − offset, computed modulo 2^24.
- R6: The phase index is phase bits [17:12], which are the six most significant fraction bits.
- R7: The state table is addressed by {mode, phase_index}, with mode in the upper two bits, and returns an 8-bit word.
- R8: A health code h (0..3) selects result = word[2h+1:2h].
- R9: kx, ky, kz, offset and mode are captured at the accepting edge. Changes to them during a sweep do not affect that sweep's results.
- R10: A table write occurs on each cycle with tbl_we_i high. tbl_sel_i picks the table: 0 = X, 1 = Y, 2 = Z (24-bit data), 3 = health (data bits [1:0]), 4 = state (data bits [7:0], address bits [7:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Sweep trigger |
| kx_i | input | 24 | X steering coefficient |
| ky_i | input | 24 | Y steering coefficient |
| kz_i | input | 24 | Z steering coefficient |
| offset_i | input | 24 | Phase offset |
| mode_i | input | 2 | State table mode |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 3 | Table select |
| tbl_addr_i | input | 9 | Table write address |
| tbl_wdata_i | input | 24 | Table write data |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| res_we_o | output | 1 | Result strobe |
| res_idx_o | output | 9 | Element index of result |
| res_o | output | 2 | Switch setting |

## Verification
The tables are filled with random positions, health codes and state words. Sweeps are then run with random coefficients, with every mode value, and with all coefficients at zero. With all coefficients at zero the phase comes from the offset alone, so any error that depends on position shows up as a mismatch. Sweeps at the most negative and most positive coefficient values exercise the sign handling and the truncation of the products, which random mid-range values seldom reach. The steering inputs are scrambled after each trigger, and one sweep also receives a trigger partway through, to show that the captured state and the sequence are held.

// File: rtl/beam_steer_pkg.sv
package beam_steer_pkg;
  typedef enum logic [2:0] {
    TBL_X      = 3'd0,
    TBL_Y      = 3'd1,
    TBL_Z      = 3'd2,
    TBL_HEALTH = 3'd3,
    TBL_STATE  = 3'd4
  } tbl_sel_e;

  localparam int unsigned NUM_AXES = 3;
endpackage

// File: rtl/bs_seq_ctrl.sv
module bs_seq_ctrl #(
  parameter int unsigned N_ELEM = 420,
  parameter int unsigned IDX_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             last_wr_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             issue_vld_o,
  output logic [IDX_W-1:0] issue_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  logic             busy_q, done_q, vld_q;
  logic [IDX_W-1:0] idx_q;

  assign start_o = trig_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last_wr_i;
      if (start_o) begin
        busy_q <= 1'b1;
        vld_q  <= 1'b1;
        idx_q  <= '0;
      end else begin
        if (last_wr_i) busy_q <= 1'b0;
        if (vld_q) begin
          if (idx_q == LAST_IDX) vld_q <= 1'b0;
          else                   idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign issue_vld_o = vld_q;
  assign issue_idx_o = idx_q;
endmodule

// File: rtl/bs_elem_tables.sv
module bs_elem_tables #(
  parameter int unsigned N_ELEM  = 420,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned FX_W    = 24,
  parameter int unsigned HLTH_W  = 2,
  parameter int unsigned TADDR_W = 9
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           tbl_we_i,
  input  logic [2:0]                                     tbl_sel_i,
  input  logic [TADDR_W-1:0]                             tbl_addr_i,
  input  logic [FX_W-1:0]                                tbl_wdata_i,
  input  logic                                           rd_vld_i,
  input  logic [IDX_W-1:0]                               rd_idx_i,
  output logic                                           vld_o,
  output logic [IDX_W-1:0]                               idx_o,
  output logic [beam_steer_pkg::NUM_AXES-1:0][FX_W-1:0]  pos_o,
  output logic [HLTH_W-1:0]                              health_o
);
  import beam_steer_pkg::*;

  logic addr_ok;
  assign addr_ok = (32'(tbl_addr_i) < N_ELEM);

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_pos
    logic [FX_W-1:0] mem [N_ELEM];
    logic            wr;
    assign wr = tbl_we_i && addr_ok && (tbl_sel_i == 3'(g));
    always_ff @(posedge clk_i) begin
      if (wr) mem[tbl_addr_i[IDX_W-1:0]] <= tbl_wdata_i;
      if (rd_vld_i) pos_o[g] <= mem[rd_idx_i];
    end
  end

  logic [HLTH_W-1:0] hmem [N_ELEM];
  logic              hwr;
  assign hwr = tbl_we_i && addr_ok && (tbl_sel_i == TBL_HEALTH);
  always_ff @(posedge clk_i) begin
    if (hwr) hmem[tbl_addr_i[IDX_W-1:0]] <= tbl_wdata_i[HLTH_W-1:0];
    if (rd_vld_i) health_o <= hmem[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      idx_o <= '0;
    end else begin
      vld_o <= rd_vld_i;
      idx_o <= rd_idx_i;
    end
  end
endmodule

// File: rtl/bs_phase_pipe.sv
module bs_phase_pipe #(
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned FX_W    = 24,
  parameter int unsigned FRAC_W  = 18,
  parameter int unsigned PIDX_W  = 6,
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned HLTH_W  = 2,
  parameter int unsigned SADDR_W = MODE_W + PIDX_W
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           vld_i,
  input  logic [IDX_W-1:0]                               idx_i,
  input  logic [beam_steer_pkg::NUM_AXES-1:0][FX_W-1:0]  pos_i,
  input  logic [HLTH_W-1:0]                              health_i,
  input  logic [beam_steer_pkg::NUM_AXES-1:0][FX_W-1:0]  coef_i,
  input  logic [FX_W-1:0]                                offset_i,
  input  logic [MODE_W-1:0]                              mode_i,
  output logic                                           vld_o,
  output logic [IDX_W-1:0]                               idx_o,
  output logic [HLTH_W-1:0]                              health_o,
  output logic [SADDR_W-1:0]                             saddr_o
);
  import beam_steer_pkg::*;

  localparam int unsigned PROD_W = 2 * FX_W;

  logic [NUM_AXES-1:0][FX_W-1:0] prod_q;
  logic                          vld2_q;
  logic [IDX_W-1:0]              idx2_q;
  logic [HLTH_W-1:0]             health2_q;

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_mul
    logic signed [FX_W-1:0]   a, b;
    logic signed [PROD_W-1:0] p;
    assign a = pos_i[g];
    assign b = coef_i[g];
    assign p = a * b;
    // back to the operand format: drop FRAC_W low bits, wrap high bits
    always_ff @(posedge clk_i) prod_q[g] <= p[FRAC_W +: FX_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld2_q    <= 1'b0;
      idx2_q    <= '0;
      health2_q <= '0;
    end else begin
      vld2_q    <= vld_i;
      idx2_q    <= idx_i;
      health2_q <= health_i;
    end
  end

  logic [FX_W-1:0] phase;
  always_comb begin
    phase = '0;
    for (int i = 0; i < NUM_AXES; i++) phase = phase + prod_q[i];
    phase = phase - offset_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      idx_o    <= '0;
      health_o <= '0;
      saddr_o  <= '0;
    end else begin
      vld_o    <= vld2_q;
      idx_o    <= idx2_q;
      health_o <= health2_q;
      saddr_o  <= {mode_i, phase[FRAC_W-1 -: PIDX_W]};
    end
  end
endmodule

// File: rtl/bs_state_sel.sv
module bs_state_sel #(
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned FX_W    = 24,
  parameter int unsigned SADDR_W = 8,
  parameter int unsigned HLTH_W  = 2,
  parameter int unsigned RES_W   = 2,
  parameter int unsigned TADDR_W = 9,
  parameter int unsigned STATE_W = RES_W * (2 ** HLTH_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [2:0]         tbl_sel_i,
  input  logic [TADDR_W-1:0] tbl_addr_i,
  input  logic [FX_W-1:0]    tbl_wdata_i,
  input  logic               vld_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [HLTH_W-1:0]  health_i,
  input  logic [SADDR_W-1:0] saddr_i,
  output logic               res_we_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [RES_W-1:0]   res_o
);
  import beam_steer_pkg::*;

  localparam int unsigned DEPTH = 2 ** SADDR_W;

  logic [STATE_W-1:0] smem [DEPTH];
  logic [STATE_W-1:0] word_q;
  logic               vld4_q;
  logic [IDX_W-1:0]   idx4_q;
  logic [HLTH_W-1:0]  health4_q;

  always_ff @(posedge clk_i) begin
    if (tbl_we_i && tbl_sel_i == TBL_STATE)
      smem[tbl_addr_i[SADDR_W-1:0]] <= tbl_wdata_i[STATE_W-1:0];
    if (vld_i) word_q <= smem[saddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld4_q    <= 1'b0;
      idx4_q    <= '0;
      health4_q <= '0;
      res_we_o  <= 1'b0;
      res_idx_o <= '0;
      res_o     <= '0;
    end else begin
      vld4_q    <= vld_i;
      idx4_q    <= idx_i;
      health4_q <= health_i;
      res_we_o  <= vld4_q;
      res_idx_o <= idx4_q;
      res_o     <= word_q[health4_q*RES_W +: RES_W];
    end
  end
endmodule

// File: rtl/beam_steer_seq.sv
module beam_steer_seq #(
  parameter int unsigned N_ELEM = 420,
  parameter int unsigned FX_W   = 24,
  parameter int unsigned FRAC_W = 18,
  parameter int unsigned PIDX_W = 6,
  parameter int unsigned MODE_W = 2,
  parameter int unsigned HLTH_W = 2,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned IDX_W   = $clog2(N_ELEM),
  localparam int unsigned SADDR_W = MODE_W + PIDX_W,
  localparam int unsigned TADDR_W = (IDX_W > SADDR_W) ? IDX_W : SADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [FX_W-1:0]    kx_i,
  input  logic [FX_W-1:0]    ky_i,
  input  logic [FX_W-1:0]    kz_i,
  input  logic [FX_W-1:0]    offset_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               tbl_we_i,
  input  logic [2:0]         tbl_sel_i,
  input  logic [TADDR_W-1:0] tbl_addr_i,
  input  logic [FX_W-1:0]    tbl_wdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               res_we_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [RES_W-1:0]   res_o
);
  import beam_steer_pkg::*;

  logic                          start_w, issue_vld, last_wr;
  logic [IDX_W-1:0]              issue_idx;
  logic [NUM_AXES-1:0][FX_W-1:0] coef_q;
  logic [FX_W-1:0]               off_q;
  logic [MODE_W-1:0]             mode_q;

  // steering inputs frozen for the whole sweep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      off_q  <= '0;
      mode_q <= '0;
    end else if (start_w) begin
      coef_q <= {kz_i, ky_i, kx_i};
      off_q  <= offset_i;
      mode_q <= mode_i;
    end
  end

  assign last_wr = res_we_o && (res_idx_o == IDX_W'(N_ELEM - 1));

  bs_seq_ctrl #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .trig_i,
    .last_wr_i   (last_wr),
    .start_o     (start_w),
    .busy_o,
    .done_o,
    .issue_vld_o (issue_vld),
    .issue_idx_o (issue_idx)
  );

  logic                          vld1;
  logic [IDX_W-1:0]              idx1;
  logic [NUM_AXES-1:0][FX_W-1:0] pos1;
  logic [HLTH_W-1:0]             health1;

  bs_elem_tables #(
    .N_ELEM(N_ELEM), .IDX_W(IDX_W), .FX_W(FX_W), .HLTH_W(HLTH_W), .TADDR_W(TADDR_W)
  ) u_tables (
    .clk_i, .rst_ni, .tbl_we_i, .tbl_sel_i, .tbl_addr_i, .tbl_wdata_i,
    .rd_vld_i (issue_vld),
    .rd_idx_i (issue_idx),
    .vld_o    (vld1),
    .idx_o    (idx1),
    .pos_o    (pos1),
    .health_o (health1)
  );

  logic               vld3;
  logic [IDX_W-1:0]   idx3;
  logic [HLTH_W-1:0]  health3;
  logic [SADDR_W-1:0] saddr3;

  bs_phase_pipe #(
    .IDX_W(IDX_W), .FX_W(FX_W), .FRAC_W(FRAC_W), .PIDX_W(PIDX_W),
    .MODE_W(MODE_W), .HLTH_W(HLTH_W), .SADDR_W(SADDR_W)
  ) u_phase (
    .clk_i, .rst_ni,
    .vld_i    (vld1),
    .idx_i    (idx1),
    .pos_i    (pos1),
    .health_i (health1),
    .coef_i   (coef_q),
    .offset_i (off_q),
    .mode_i   (mode_q),
    .vld_o    (vld3),
    .idx_o    (idx3),
    .health_o (health3),
    .saddr_o  (saddr3)
  );

  bs_state_sel #(
    .IDX_W(IDX_W), .FX_W(FX_W), .SADDR_W(SADDR_W), .HLTH_W(HLTH_W),
    .RES_W(RES_W), .TADDR_W(TADDR_W)
  ) u_state (
    .clk_i, .rst_ni, .tbl_we_i, .tbl_sel_i, .tbl_addr_i, .tbl_wdata_i,
    .vld_i    (vld3),
    .idx_i    (idx3),
    .health_i (health3),
    .saddr_i  (saddr3),
    .res_we_o,
    .res_idx_o,
    .res_o
  );
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int unsigned N_ELEM = 420,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned W      = 76
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             res_we_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic [W-1:0]     shadow
);
  logic last;
  assign last = res_we_o && (res_idx_o == IDX_W'(N_ELEM - 1));

  p_we_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> busy_o);
  p_done_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> done_o && !busy_o);
  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_trig_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && trig_i && !last |=> busy_o);
  p_first_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o && !$past(res_we_o) |-> res_idx_o == '0);
  p_idx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o && $past(res_we_o) |-> res_idx_o == $past(res_idx_o) + 1'b1);
  p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(shadow));
endmodule

bind beam_steer_seq bs_checker #(
  .N_ELEM(N_ELEM), .IDX_W(IDX_W), .W(3 * FX_W + FX_W + MODE_W)
) u_chk (
  .clk_i, .rst_ni, .trig_i, .busy_o, .done_o, .res_we_o, .res_idx_o,
  .shadow ({coef_q, off_q, mode_q})
);

// File: tb/beam_steer_seq_bench.sv
`timescale 1ns/1ps
module beam_steer_seq_bench;
  localparam int N = 420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [23:0] kx = '0, ky = '0, kz = '0, off = '0;
  logic [1:0]  mode = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic [8:0]  tbl_addr = '0;
  logic [23:0] tbl_wdata = '0;
  logic        busy, done, res_we;
  logic [8:0]  res_idx;
  logic [1:0]  res;

  always #2 clk = ~clk;

  beam_steer_seq u_beam_steer_seq (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .kx_i(kx), .ky_i(ky), .kz_i(kz), .offset_i(off), .mode_i(mode),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
    .busy_o(busy), .done_o(done), .res_we_o(res_we), .res_idx_o(res_idx), .res_o(res)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [23:0] mx[N], my[N], mz[N];
  logic [1:0]  mh[N];
  logic [7:0]  ms[256];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] trunc_mul(input logic [23:0] a, input logic [23:0] b);
    logic signed [47:0] p;
    p = $signed(a) * $signed(b);
    return p[41:18];
  endfunction

  function automatic logic [1:0] model(input int k, input logic [23:0] cx, input logic [23:0] cy,
                                       input logic [23:0] cz, input logic [23:0] co,
                                       input logic [1:0] md);
    logic [23:0] ph;
    logic [7:0]  w;
    ph = trunc_mul(mx[k], cx) + trunc_mul(my[k], cy) + trunc_mul(mz[k], cz) - co;  // R5
    w  = ms[{md, ph[17:12]}];                                                        // R6 R7
    return w[2*mh[k] +: 2];                                                          // R8
  endfunction

  task automatic wr(input logic [2:0] sel, input int a, input logic [23:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 9'(a); tbl_wdata = d;
  endtask

  task automatic sweep(input logic [23:0] cx, input logic [23:0] cy, input logic [23:0] cz,
                       input logic [23:0] co, input logic [1:0] md, input bit poke);
    int nw = 0, cyc = 1;
    bit got_done = 0;
    @(negedge clk);
    kx = cx; ky = cy; kz = cz; off = co; mode = md; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    // R9: scramble steering inputs right after capture
    kx = $urandom; ky = $urandom; kz = $urandom; off = $urandom; mode = 2'($urandom);
    chk(busy == 1'b1, "R2 busy after trigger", busy, 1);
    while (!got_done && cyc < 440) begin
      if (res_we) begin
        if (nw == 0) chk(cyc == 6, "R4 first strobe latency", cyc, 6);
        chk(res_idx == 9'(nw), "R4 index order", res_idx, nw);
        chk(res == model(nw, cx, cy, cz, co, md), "R5-R8 result R9", res,
            model(nw, cx, cy, cz, co, md));
        nw++;
      end
      if (done) begin
        got_done = 1;
        chk(nw == N, "R3 result count", nw, N);
        chk(cyc == 426, "R2 done timing", cyc, 426);
        chk(busy == 1'b0, "R2 busy low at done", busy, 0);
      end
      if (poke) trig = (cyc == 100);  // R3 trigger while busy
      if (!got_done) begin
        @(negedge clk);
        cyc++;
      end
    end
    trig = 1'b0;
    chk(got_done, "R2 done seen", got_done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bea_5eed));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && res_we == 0, "R1 reset outputs", {busy, done, res_we}, 0);
    rst_n = 1'b1;
    // R10: load all tables through the write port
    for (int k = 0; k < N; k++) begin
      mx[k] = $urandom; my[k] = $urandom; mz[k] = $urandom; mh[k] = 2'($urandom);
      wr(3'd0, k, mx[k]); wr(3'd1, k, my[k]); wr(3'd2, k, mz[k]); wr(3'd3, k, 24'(mh[k]));
    end
    for (int a = 0; a < 256; a++) begin
      ms[a] = 8'($urandom);
      wr(3'd4, a, 24'(ms[a]));
    end
    @(negedge clk);
    tbl_we = 1'b0;
    chk(busy == 0, "R1 idle after load", busy, 0);
    // directed: zero coefficients, phase set by offset only
    sweep(24'h0, 24'h0, 24'h0, 24'h02_5000, 2'd1, 0);
    // directed: extreme coefficients
    sweep(24'h800000, 24'h7fffff, 24'h800000, 24'h7fffff, 2'd3, 0);
    // random sweeps over every mode, one with a mid-sweep trigger
    for (int m = 0; m < 4; m++)
      sweep($urandom, $urandom, $urandom, $urandom, 2'(m), m == 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule